// File: doc/BRIEF.md
# Multi-counter event monitor

The block counts hardware events for performance profiling. It holds eight 32-bit counters. Each counter has a one-byte event code that picks one of 256 event strobes from the `evt_i` bus. While the global run bit is set and its code is non-zero, a counter adds one in every cycle in which its chosen strobe is high.

To take a sample every N events, software loads a counter with the two's-complement negative of N. When the counter wraps to zero, it raises a sticky overflow flag. If the interrupt enable for that counter is set, its own interrupt line goes high. Software clears the flag by writing a one to the flag's bit in the shared control word.

All state is reached through a synchronous single-cycle register port. A write lands at the clock edge, and a read returns data combinationally from the address.

Top module: `emon_unit`

## Requirements
- R1: Counter n (n = 0..7) is a 32-bit register at address 0x10+n that software can write and read back.
- R2: The event code of counter n sits at address 0x08+n. Only write-data bits 7:0 are stored, and a read returns them zero-extended. A code of 0 stops that counter from counting.
- R3: The control word at address 0x00 has the global run bit at bit 0. While the run bit is 0, no counter changes except by a software write.
- R4: A counter adds exactly one in each cycle in which the run bit is set, its code is non-zero and `evt_i[code]` is high. A strobe that no counter selects changes nothing.
- R5: A counter preset to the 32-bit value 2^32-N reads 0 after exactly N counted events.
- R6: When a counter wraps from 0xFFFFFFFF to 0, its overflow flag at control bit 16+n becomes 1.
- R7: `irq_o[n]` is high exactly while overflow flag n and interrupt enable n (control bit 8+n) are both set.
- R8: Writing 1 to control bit 16+n clears that flag. Writing 0 to it leaves the flag as it was. An overflow in the same cycle as a clear leaves the flag set.
- R9: After reset, every counter, every event code and the whole control word read 0, and all interrupt lines are low.
- R10: When a software write to a counter and a counted event fall in the same cycle, the counter takes the written value.
- R11: A write to the control word takes effect at the clock edge of that write, so the run bit first gates counting in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 5 | Register address |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data, combinational from addr_i |
| evt_i | input | 256 | Event strobes, one per event code |
| irq_o | output | 8 | One interrupt line per counter |

## Verification
Each counter is given a distinct event code, and the strobe it selects is held high for a different number of cycles. This shows whether the counters pick the right strobe or are swapped or shared. A burst on every strobe at once checks that each counter adds exactly one per cycle. A burst on a strobe that no counter selects, a burst with the run bit cleared, and a burst with one code set to 0 (all strobes high, bit 0 included) separate real gating from counting that merely looks idle. Counters preset just below the wrap point, with and without their interrupt enable, tell apart the flag, the interrupt and the write-one-to-clear behaviour. A counter write made while its strobe stays high shows which source wins.

// File: rtl/emon_pkg.sv
package emon_pkg;
  localparam int NUM_CNT  = 8;
  localparam int CNT_W    = 32;
  localparam int EVT_W    = 8;
  localparam int NUM_EVT  = 1 << EVT_W;
  localparam int ADDR_W   = 5;
  localparam int DATA_W   = 32;
  localparam int CTRL_ADR = 0;
  localparam int SEL_BASE = 8;
  localparam int CNT_BASE = 16;
  localparam int RUN_BIT  = 0;
  localparam int IE_LSB   = 8;
  localparam int OVF_LSB  = 16;
endpackage

// File: rtl/emon_counter.sv
module emon_counter #(
  parameter int CNT_W   = 32,
  parameter int EVT_W   = 8,
  parameter int NUM_EVT = 1 << EVT_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               run_i,
  input  logic               sel_we_i,
  input  logic               cnt_we_i,
  input  logic [CNT_W-1:0]   wdata_i,
  input  logic [NUM_EVT-1:0] evt_i,
  output logic [EVT_W-1:0]   sel_o,
  output logic [CNT_W-1:0]   cnt_o,
  output logic               ovf_o
);
  logic [EVT_W-1:0] sel_q;
  logic [CNT_W-1:0] cnt_q;
  logic             hit;

  assign hit   = run_i && (sel_q != '0) && evt_i[sel_q];
  // software write suppresses the increment and its wrap
  assign ovf_o = hit && !cnt_we_i && (&cnt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= '0;
      cnt_q <= '0;
    end else begin
      if (sel_we_i) sel_q <= wdata_i[EVT_W-1:0];
      if (cnt_we_i)  cnt_q <= wdata_i;
      else if (hit)  cnt_q <= cnt_q + 1'b1;
    end
  end

  assign sel_o = sel_q;
  assign cnt_o = cnt_q;

  // R4: without a write the counter holds or steps by one
  a_r4_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cnt_we_i |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + 1'b1));
  // R2
  a_r2_code_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_q == '0 && !cnt_we_i) |=> $stable(cnt_q));
  // R3
  a_r3_halt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !cnt_we_i) |=> $stable(cnt_q));
  // R6
  a_r6_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> (cnt_q == '0));
  // R10
  a_r10_write_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_we_i |=> (cnt_q == $past(wdata_i)));
endmodule

// File: rtl/emon_ctrl.sv
module emon_ctrl #(
  parameter int NUM_CNT = 8,
  parameter int DATA_W  = 32,
  parameter int RUN_BIT = 0,
  parameter int IE_LSB  = 8,
  parameter int OVF_LSB = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic [NUM_CNT-1:0] ovf_set_i,
  output logic               run_o,
  output logic [DATA_W-1:0]  ctrl_o,
  output logic [NUM_CNT-1:0] irq_o
);
  logic               run_q;
  logic [NUM_CNT-1:0] ie_q;
  logic [NUM_CNT-1:0] flag_q;
  logic [NUM_CNT-1:0] clr;
  logic               unused_wdata;

  assign unused_wdata = ^wdata_i;
  assign clr = we_i ? wdata_i[OVF_LSB +: NUM_CNT] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      ie_q   <= '0;
      flag_q <= '0;
    end else begin
      if (we_i) begin
        run_q <= wdata_i[RUN_BIT];
        ie_q  <= wdata_i[IE_LSB +: NUM_CNT];
      end
      // set beats clear
      flag_q <= (flag_q & ~clr) | ovf_set_i;
    end
  end

  always_comb begin
    ctrl_o                       = '0;
    ctrl_o[RUN_BIT]              = run_q;
    ctrl_o[IE_LSB  +: NUM_CNT]   = ie_q;
    ctrl_o[OVF_LSB +: NUM_CNT]   = flag_q;
  end

  assign run_o = run_q;
  assign irq_o = flag_q & ie_q;

  // R6
  a_r6_flag_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_set_i != '0) |=> ((flag_q & $past(ovf_set_i)) == $past(ovf_set_i)));
  // R8: a flag only drops on a control write
  a_r8_clear_by_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((~flag_q & $past(flag_q)) != '0) |-> $past(we_i));
  // R7
  a_r7_irq_needs_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((irq_o & ~flag_q) == '0));
endmodule

// File: rtl/emon_unit.sv
module emon_unit #(
  parameter int NUM_CNT = emon_pkg::NUM_CNT,
  parameter int CNT_W   = emon_pkg::CNT_W,
  parameter int EVT_W   = emon_pkg::EVT_W,
  parameter int ADDR_W  = emon_pkg::ADDR_W,
  parameter int DATA_W  = emon_pkg::DATA_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    we_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [DATA_W-1:0]       wdata_i,
  output logic [DATA_W-1:0]       rdata_o,
  input  logic [(1<<EVT_W)-1:0]   evt_i,
  output logic [NUM_CNT-1:0]      irq_o
);
  import emon_pkg::*;
  localparam int NEVT = 1 << EVT_W;

  logic [EVT_W-1:0]   sel_w [NUM_CNT];
  logic [CNT_W-1:0]   cnt_w [NUM_CNT];
  logic [NUM_CNT-1:0] ovf_w;
  logic [DATA_W-1:0]  ctrl_w;
  logic               run_w;
  logic               ctrl_we;

  assign ctrl_we = we_i && (addr_i == ADDR_W'(CTRL_ADR));

  emon_ctrl #(
    .NUM_CNT(NUM_CNT), .DATA_W(DATA_W),
    .RUN_BIT(RUN_BIT), .IE_LSB(IE_LSB), .OVF_LSB(OVF_LSB)
  ) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (ctrl_we),
    .wdata_i   (wdata_i),
    .ovf_set_i (ovf_w),
    .run_o     (run_w),
    .ctrl_o    (ctrl_w),
    .irq_o     (irq_o)
  );

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    logic sel_we, cnt_we;
    assign sel_we = we_i && (addr_i == ADDR_W'(SEL_BASE + i));
    assign cnt_we = we_i && (addr_i == ADDR_W'(CNT_BASE + i));

    emon_counter #(.CNT_W(CNT_W), .EVT_W(EVT_W), .NUM_EVT(NEVT)) u_cnt (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .run_i    (run_w),
      .sel_we_i (sel_we),
      .cnt_we_i (cnt_we),
      .wdata_i  (wdata_i[CNT_W-1:0]),
      .evt_i    (evt_i),
      .sel_o    (sel_w[i]),
      .cnt_o    (cnt_w[i]),
      .ovf_o    (ovf_w[i])
    );
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(CTRL_ADR)) rdata_o = ctrl_w;
    for (int i = 0; i < NUM_CNT; i++) begin
      if (addr_i == ADDR_W'(SEL_BASE + i)) rdata_o = DATA_W'(sel_w[i]);
      if (addr_i == ADDR_W'(CNT_BASE + i)) rdata_o = DATA_W'(cnt_w[i]);
    end
  end

  // R7: interrupt lines follow flag and enable
  a_r7_irq_map: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (ctrl_w[OVF_LSB +: NUM_CNT] & ctrl_w[IE_LSB +: NUM_CNT]));
endmodule

// File: tb/tb_emon_unit.sv
module tb_emon_unit;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         we = 1'b0;
  logic [4:0]   addr = '0;
  logic [31:0]  wdata = '0;
  logic [31:0]  rdata;
  logic [255:0] evt = '0;
  logic [7:0]   irq;
  int           n_chk = 0;
  int           n_fail = 0;
  logic [31:0]  exp_cnt [8];

  always #5 clk = ~clk;

  emon_unit dut (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .evt_i(evt), .irq_o(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic strobe(input logic [255:0] v, input int cycles);
    @(negedge clk);
    evt = v;
    repeat (cycles) @(negedge clk);
    evt = '0;
  endtask

  function automatic logic [7:0] code_of(input int n);
    return 8'(n * 36 + 3);
  endfunction

  task automatic check_all_counts(input string req);
    logic [31:0] d;
    for (int n = 0; n < 8; n++) begin
      rd(5'(16 + n), d);
      check(req, d, exp_cnt[n]);
    end
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0]  d;
    logic [255:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9: reset state
    rd(5'h00, d); check("R9 ctrl", d, 32'h0);
    for (int n = 0; n < 8; n++) begin
      rd(5'(8 + n), d);  check("R9 sel", d, 32'h0);
      rd(5'(16 + n), d); check("R9 cnt", d, 32'h0);
    end
    check("R9 irq", 32'(irq), 32'h0);

    // R1: count registers write/read
    for (int n = 0; n < 8; n++) wr(5'(16 + n), 32'hA5000000 + 32'(n * 32'h01010101));
    for (int n = 0; n < 8; n++) begin
      rd(5'(16 + n), d);
      check("R1 cnt rw", d, 32'hA5000000 + 32'(n * 32'h01010101));
    end
    // R2: only low byte of code stored
    for (int n = 0; n < 8; n++) wr(5'(8 + n), 32'hFFFF_FF00 | 32'(code_of(n)));
    for (int n = 0; n < 8; n++) begin
      rd(5'(8 + n), d);
      check("R2 sel byte", d, 32'(code_of(n)));
    end
    for (int n = 0; n < 8; n++) begin
      wr(5'(16 + n), 32'h0);
      exp_cnt[n] = 0;
    end

    // R3: strobes with run bit clear
    strobe('1, 4);
    check_all_counts("R3 halted");

    // R11: enable, then counting starts the following cycle
    wr(5'h00, 32'h1);
    rd(5'h00, d); check("R11 run bit", d, 32'h1);

    // R4: each counter with its own strobe and duration
    for (int n = 0; n < 8; n++) begin
      v = '0; v[code_of(n)] = 1'b1;
      strobe(v, n + 2);
      exp_cnt[n] += 32'(n + 2);
    end
    check_all_counts("R4 per-event");
    // R4: all at once
    strobe('1, 5);
    for (int n = 0; n < 8; n++) exp_cnt[n] += 5;
    check_all_counts("R4 all strobes");
    // R4: unselected strobe
    v = '0; v[2] = 1'b1; v[200] = 1'b1;
    strobe(v, 4);
    check_all_counts("R4 unselected");

    // R3: run cleared again
    wr(5'h00, 32'h0);
    strobe('1, 3);
    check_all_counts("R3 halted again");

    // R2: code 0 on counter 7 blocks counting even with bit 0 high
    wr(5'(8 + 7), 32'h100);
    rd(5'(8 + 7), d); check("R2 code zero", d, 32'h0);
    wr(5'h00, 32'h1);
    strobe('1, 3);
    for (int n = 0; n < 7; n++) exp_cnt[n] += 3;
    check_all_counts("R2 code zero counts");

    // R5/R6/R7: counter 0 with irq enabled, counter 1 without
    wr(5'h00, 32'h0000_0101);
    wr(5'h10, 32'hFFFF_FFFD);
    wr(5'h11, 32'hFFFF_FFFF);
    v = '0; v[code_of(0)] = 1'b1;
    strobe(v, 2);
    rd(5'h10, d); check("R5 before wrap", d, 32'hFFFF_FFFF);
    rd(5'h00, d); check("R6 no flag yet", d, 32'h0000_0101);
    check("R7 irq low", 32'(irq), 32'h0);
    strobe(v, 1);
    rd(5'h10, d); check("R5 wrapped after 3", d, 32'h0);
    rd(5'h00, d); check("R6 flag0", d, 32'h0001_0101);
    check("R7 irq0 high", 32'(irq), 32'h1);
    v = '0; v[code_of(1)] = 1'b1;
    strobe(v, 1);
    rd(5'h11, d); check("R5 cnt1 wrap", d, 32'h0);
    rd(5'h00, d); check("R6 flag1", d, 32'h0003_0101);
    check("R7 irq1 masked", 32'(irq), 32'h1);

    // R8: writing zero keeps flags, writing one clears
    wr(5'h00, 32'h0000_0101);
    rd(5'h00, d); check("R8 zero keeps", d, 32'h0003_0101);
    check("R8 irq kept", 32'(irq), 32'h1);
    wr(5'h00, 32'h0001_0101);
    rd(5'h00, d); check("R8 clear flag0", d, 32'h0002_0101);
    check("R8 irq0 dropped", 32'(irq), 32'h0);
    // R7: enabling irq1 exposes pending flag1
    wr(5'h00, 32'h0000_0301);
    check("R7 irq1 on enable", 32'(irq), 32'h2);
    wr(5'h00, 32'h0002_0301);
    check("R8 irq1 cleared", 32'(irq), 32'h0);

    // R8: overflow in same cycle as clear keeps flag
    wr(5'h12, 32'hFFFF_FFFF);
    @(negedge clk);
    evt[code_of(2)] = 1'b1;
    we = 1'b1; addr = 5'h00; wdata = 32'h0004_0301;
    @(negedge clk);
    we = 1'b0; evt = '0;
    rd(5'h00, d); check("R8 set beats clear", d, 32'h0004_0301);

    // R10: software write wins over a counted event
    v = '0; v[code_of(3)] = 1'b1;
    @(negedge clk);
    evt = v;
    we = 1'b1; addr = 5'h13; wdata = 32'd100;
    @(negedge clk);
    we = 1'b0; evt = '0;
    rd(5'h13, d); check("R10 write wins", d, 32'd100);

    // R9: reset again clears everything
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    rd(5'h00, d); check("R9 ctrl after reset", d, 32'h0);
    rd(5'h13, d); check("R9 cnt after reset", d, 32'h0);
    rd(5'h08, d); check("R9 sel after reset", d, 32'h0);
    check("R9 irq after reset", 32'(irq), 32'h0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule